// File: doc/BRIEF.md
# Burst Bus Target with Register File

This block is the target side of a synchronous bus that carries address and data on one set of lines, one after the other. An initiator starts a transaction by pulling the active-low transaction line low. It puts a word address on the shared lines and a command on the command lines during that first edge. The target compares the address with its decoded window. If the address falls inside and the command is a memory read or a memory write, the target claims the transaction. It then moves one word on every rising edge at which both the initiator-ready and target-ready lines are low.

The burst has no fixed length. The initiator raises the transaction line while it still presents the final word, and the burst ends with that transfer. The register-file index starts at the low bits of the address-phase word address and advances by one after each completed transfer, wrapping at the end of the file. On a read, the target leaves the shared lines undriven for one turnaround cycle after the address phase. It holds target-ready deasserted for a configurable number of wait states before the first word only. Every output is registered. Each pin that can be released has its own enable, and an enable of 0 stands for the pin being left undriven.

Top module: `burst_target`

## Requirements
- R1: While reset is high, and in the cycle after it, `ad_oe` and `tgt_rdy_oe` are 0 and `tgt_rdy_n` is 1.
- R2: On a claimed read, `ad_oe` is 0 in the cycle after the address-phase edge, which is the turnaround cycle, while `tgt_rdy_oe` is already 1.
- R3: On a claimed transaction, `tgt_rdy_n` stays 1 for exactly WAIT_STATES+1 cycles after the address-phase edge, then goes low. It does not go high again before the burst ends. `tgt_rdy_n` is low only while `tgt_rdy_oe` is 1.
- R4: No word moves on an edge where `init_rdy_n` is 1. During such a stall on a read, `ad_out` keeps its value, and the index does not advance.
- R5: A write burst stores the word on `ad_in` at each edge where both ready lines are low, at consecutive indices starting from the low address bits.
- R6: A read burst presents the word at consecutive indices on `ad_out` with `ad_oe` 1, valid in every cycle where `tgt_rdy_n` is low.
- R7: After the edge that moves a word while `txn_n` is 1, the target drives `tgt_rdy_n` to 1 and releases `ad_oe` for one cycle. It releases `tgt_rdy_oe` in the cycle after that.
- R8: The decoded window is the DEPTH word addresses from BASE_WADDR upward. A transaction whose address lies outside this window is ignored: both enables stay 0 and no stored word changes.
- R9: Command 4'h6 is a memory read and 4'h7 is a memory write. Any other command is ignored, with both enables staying 0 and no stored word changing.
- R10: The index wraps from DEPTH-1 to 0 within a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all lines sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| txn_n | input | 1 | Active-low transaction line from the initiator |
| cmd | input | 4 | Command, valid in the address phase |
| ad_in | input | DW | Shared address/data lines as seen by the target |
| init_rdy_n | input | 1 | Active-low initiator ready |
| ad_out | output | DW | Read data the target drives onto the shared lines |
| ad_oe | output | 1 | 1 when the target drives the shared lines |
| tgt_rdy_n | output | 1 | Active-low target ready |
| tgt_rdy_oe | output | 1 | 1 when the target drives its ready line |

## Verification
The bench builds the block with DEPTH 16 and WAIT_STATES 2, with the window at word address 0x100. Two wait states make the count of held target-ready cycles distinguishable from off-by-one variants. The small file lets a four-word burst starting at index 14 cross the wrap point. Out-of-window and foreign-command transactions are aimed at an index already written, so that a stray write would show up in a later read.

// File: rtl/burst_target_pkg.sv
package burst_target_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'h6;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_WAIT,
    ST_DATA,
    ST_END
  } tgt_state_e;
endpackage

// File: rtl/burst_target_decode.sv
module burst_target_decode #(
  parameter int          DW         = 32,
  parameter int          AW         = 4,
  parameter logic [31:0] BASE_WADDR = 32'h0000_0100
) (
  input  logic [DW-1:0] addr,
  input  logic [3:0]    cmd,
  output logic          hit,
  output logic          is_rd,
  output logic          is_wr
);
  import burst_target_pkg::*;
  localparam logic [DW-1:0] BASE_W = DW'(BASE_WADDR);

  always_comb begin
    hit   = (addr[DW-1:AW] == BASE_W[DW-1:AW]);
    is_rd = (cmd == CMD_MEM_RD);
    is_wr = (cmd == CMD_MEM_WR);
  end
endmodule

// File: rtl/burst_target_regfile.sv
module burst_target_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/burst_target_ctrl.sv
module burst_target_ctrl #(
  parameter int DEPTH       = 16,
  parameter int WAIT_STATES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int WCW        = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txn_n,
  input  logic          init_rdy_n,
  input  logic          hit,
  input  logic          cmd_rd,
  input  logic          cmd_wr,
  input  logic [AW-1:0] addr_idx,
  output logic          we,
  output logic [AW-1:0] idx,
  output logic [AW-1:0] rd_idx,
  output logic          ad_oe,
  output logic          tgt_rdy_n,
  output logic          tgt_rdy_oe
);
  import burst_target_pkg::*;

  tgt_state_e     state;
  logic           rd_txn;
  logic [WCW-1:0] wcnt;
  logic           xfer;

  always_comb begin
    xfer   = (state == ST_DATA) && !init_rdy_n && !tgt_rdy_n;
    we     = xfer && !rd_txn;
    rd_idx = xfer ? idx + AW'(1) : idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rd_txn     <= 1'b0;
      wcnt       <= '0;
      idx        <= '0;
      ad_oe      <= 1'b0;
      tgt_rdy_n  <= 1'b1;
      tgt_rdy_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!txn_n) begin
            if (hit && (cmd_rd || cmd_wr)) begin
              state      <= ST_WAIT;
              rd_txn     <= cmd_rd;
              idx        <= addr_idx;
              wcnt       <= '0;
              tgt_rdy_oe <= 1'b1;
              tgt_rdy_n  <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_SKIP: begin
          if (txn_n && init_rdy_n) state <= ST_IDLE;
        end
        ST_WAIT: begin
          if (rd_txn) ad_oe <= 1'b1;
          if (wcnt == WCW'(WAIT_STATES)) begin
            tgt_rdy_n <= 1'b0;
            state     <= ST_DATA;
          end else begin
            wcnt <= wcnt + WCW'(1);
          end
        end
        ST_DATA: begin
          if (xfer) begin
            idx <= idx + AW'(1);
            if (txn_n) begin
              state     <= ST_END;
              tgt_rdy_n <= 1'b1;
              ad_oe     <= 1'b0;
            end
          end
        end
        ST_END: begin
          tgt_rdy_oe <= 1'b0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_target.sv
module burst_target #(
  parameter int          DW          = 32,
  parameter int          DEPTH       = 16,
  parameter int          WAIT_STATES = 2,
  parameter logic [31:0] BASE_WADDR  = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txn_n,
  input  logic [3:0]    cmd,
  input  logic [DW-1:0] ad_in,
  input  logic          init_rdy_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          tgt_rdy_n,
  output logic          tgt_rdy_oe
);
  localparam int AW = $clog2(DEPTH);

  logic          hit, cmd_rd, cmd_wr, we;
  logic [AW-1:0] idx, rd_idx;

  burst_target_decode #(.DW(DW), .AW(AW), .BASE_WADDR(BASE_WADDR)) u_dec (
    .addr(ad_in), .cmd(cmd), .hit(hit), .is_rd(cmd_rd), .is_wr(cmd_wr)
  );

  burst_target_ctrl #(.DEPTH(DEPTH), .WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk(clk), .rst(rst), .txn_n(txn_n), .init_rdy_n(init_rdy_n),
    .hit(hit), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .addr_idx(ad_in[AW-1:0]),
    .we(we), .idx(idx), .rd_idx(rd_idx), .ad_oe(ad_oe),
    .tgt_rdy_n(tgt_rdy_n), .tgt_rdy_oe(tgt_rdy_oe)
  );

  burst_target_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .we(we), .waddr(idx), .wdata(ad_in),
    .raddr(rd_idx), .rdata(ad_out)
  );
endmodule

// File: rtl/burst_target_chk.sv
module burst_target_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          txn_n,
  input logic          init_rdy_n,
  input logic [DW-1:0] ad_out,
  input logic          ad_oe,
  input logic          tgt_rdy_n,
  input logic          tgt_rdy_oe
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ad_oe && !tgt_rdy_oe && tgt_rdy_n));

  a_r2_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_rdy_oe) |-> !ad_oe);

  a_r3_ready_only_when_driven: assert property (@(posedge clk) disable iff (rst)
    !tgt_rdy_n |-> tgt_rdy_oe);

  a_r4_stall_holds_data: assert property (@(posedge clk) disable iff (rst)
    (ad_oe && $past(ad_oe) && $past(init_rdy_n) && !$past(tgt_rdy_n)) |-> $stable(ad_out));

  a_r7_release_after_last: assert property (@(posedge clk) disable iff (rst)
    $past(!tgt_rdy_n && !init_rdy_n && txn_n && tgt_rdy_oe) |-> (tgt_rdy_n && !ad_oe));

  a_r8_data_only_when_claimed: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> tgt_rdy_oe);
endmodule

bind burst_target burst_target_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .txn_n(txn_n), .init_rdy_n(init_rdy_n),
  .ad_out(ad_out), .ad_oe(ad_oe), .tgt_rdy_n(tgt_rdy_n), .tgt_rdy_oe(tgt_rdy_oe)
);

// File: tb/sim_burst_target.sv
module sim_burst_target;
  localparam int CLK_PERIOD = 10;
  localparam int WAITS = 2;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txn_n = 1'b1;
  logic [3:0]  cmd = 4'h0;
  logic [31:0] ad_in = '0;
  logic        init_rdy_n = 1'b1;
  logic [31:0] ad_out;
  logic        ad_oe, tgt_rdy_n, tgt_rdy_oe;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_target #(.DW(32), .DEPTH(16), .WAIT_STATES(WAITS), .BASE_WADDR(BASE)) u0 (
    .clk(clk), .rst(rst), .txn_n(txn_n), .cmd(cmd), .ad_in(ad_in),
    .init_rdy_n(init_rdy_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .tgt_rdy_n(tgt_rdy_n), .tgt_rdy_oe(tgt_rdy_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One burst; stall_at < 0 means no initiator stall
  task automatic burst(input bit wr, input logic [31:0] addr, input int n,
                       input int stall_at, input int seed);
    int i = 0;
    int hi = 0;
    int guard = 0;
    bit stalled = 0;
    logic [31:0] hold;
    logic [3:0] ix;
    @(negedge clk);
    txn_n = 1'b0; init_rdy_n = 1'b1; cmd = wr ? 4'h7 : 4'h6; ad_in = addr;
    @(negedge clk);
    chk(tgt_rdy_oe === 1'b1, "R3 claim", 32'(tgt_rdy_oe), 32'd1);
    if (!wr) chk(ad_oe === 1'b0, "R2 turnaround", 32'(ad_oe), 32'd0);
    init_rdy_n = 1'b0; txn_n = (n == 1); cmd = 4'h0;
    ad_in = wr ? 32'hC0DE_0000 + 32'(seed * 256) : '0;
    while (i < n && guard < 200) begin
      guard++;
      ix = addr[3:0] + 4'(i);
      if (tgt_rdy_n) begin
        hi++;
        @(negedge clk);
      end else if (stall_at == i && !stalled) begin
        stalled = 1;
        init_rdy_n = 1'b1;
        hold = ad_out;
        @(negedge clk);
        if (!wr) chk(ad_out === hold, "R4 stall hold", ad_out, hold);
        chk(tgt_rdy_n === 1'b0, "R3 stays ready", 32'(tgt_rdy_n), 32'd0);
        init_rdy_n = 1'b0;
      end else begin
        if (wr) model[ix] = ad_in;
        else begin
          chk(ad_oe === 1'b1, "R6 drive", 32'(ad_oe), 32'd1);
          chk(ad_out === model[ix], "R6 read word", ad_out, model[ix]);
        end
        i++;
        @(negedge clk);
        if (i < n) begin
          txn_n = (i == n - 1);
          ad_in = wr ? 32'hC0DE_0000 + 32'(seed * 256 + i) : '0;
        end else begin
          init_rdy_n = 1'b1;
        end
      end
    end
    chk(hi == WAITS + 1, "R3 wait count", 32'(hi), 32'(WAITS + 1));
    chk(tgt_rdy_n === 1'b1 && tgt_rdy_oe === 1'b1 && ad_oe === 1'b0, "R7 end cycle",
        {29'd0, tgt_rdy_n, tgt_rdy_oe, ad_oe}, 32'b110);
    @(negedge clk);
    chk(tgt_rdy_oe === 1'b0, "R7 release", 32'(tgt_rdy_oe), 32'd0);
    @(negedge clk);
  endtask

  task automatic ignored(input logic [31:0] addr, input logic [3:0] c, input string req);
    bit ok = 1;
    @(negedge clk);
    txn_n = 1'b0; init_rdy_n = 1'b1; cmd = c; ad_in = addr;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (ad_oe !== 1'b0 || tgt_rdy_oe !== 1'b0) ok = 0;
      init_rdy_n = 1'b0; cmd = 4'h0; ad_in = 32'hDEAD_0000 + 32'(k);
      txn_n = (k >= 4);
    end
    chk(ok, req, {30'd0, ad_oe, tgt_rdy_oe}, 32'd0);
    init_rdy_n = 1'b1; txn_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ad_oe === 1'b0 && tgt_rdy_oe === 1'b0 && tgt_rdy_n === 1'b1, "R1 in reset",
        {29'd0, ad_oe, tgt_rdy_oe, tgt_rdy_n}, 32'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(ad_oe === 1'b0 && tgt_rdy_oe === 1'b0 && tgt_rdy_n === 1'b1, "R1 after reset",
        {29'd0, ad_oe, tgt_rdy_oe, tgt_rdy_n}, 32'b001);
  endtask

  task automatic t_write_read;
    burst(1'b1, BASE + 32'd2, 5, -1, 1);   // R5 write burst
    burst(1'b0, BASE + 32'd2, 5, 2, 0);    // R6 read back, R4 stall
  endtask

  task automatic t_single;
    burst(1'b1, BASE + 32'd9, 1, -1, 2);
    burst(1'b0, BASE + 32'd9, 1, -1, 0);
  endtask

  task automatic t_wrap;
    burst(1'b1, BASE + 32'd14, 4, 1, 3);   // R10 indices 14,15,0,1; write stall R4
    burst(1'b0, BASE + 32'd14, 4, -1, 0);
    burst(1'b0, BASE + 32'd0, 2, -1, 0);
  endtask

  task automatic t_out_of_range;
    ignored(32'h0000_0209, 4'h7, "R8 no claim out of window");
    ignored(BASE + 32'h10 + 32'd9, 4'h7, "R8 no claim next window");
    burst(1'b0, BASE + 32'd9, 1, -1, 0);   // R8 stored word unchanged
  endtask

  task automatic t_bad_cmd;
    ignored(BASE + 32'd9, 4'h3, "R9 foreign command");
    ignored(BASE + 32'd9, 4'h6 ^ 4'h8, "R9 near-miss command");
    burst(1'b0, BASE + 32'd9, 1, -1, 0);   // R9 stored word unchanged
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_single();
    t_wrap();
    t_out_of_range();
    t_bad_cmd();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule